// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This unit forms the 9-bit data-memory address for a small 8-bit accumulator core and sequences the read and write strobes toward a synchronous data RAM. Each file-register access names a 7-bit file offset. Most offsets are direct: the two bank-select bits of the status register are placed above the offset. Offset 7'h00 is the indirect-data pseudo-register. An access to it goes to the location held in the file select register (FSR). The indirect-bank bit of the status register is placed above the 8-bit FSR value.

An indirect access whose effective address has 7'h00 in its low seven bits points back at the pseudo-register, in any bank. That access reads as 8'h00 and its write is dropped. The core starts an operation with a one-cycle `start` pulse that carries read and/or write requests. A read-modify-write reads the RAM first and writes back two cycles later to the same latched address. The core supplies the write data during the write cycle.

The controller has four states. `ST_IDLE` waits for work. `ST_READ` drives the read strobe. `ST_CAPT` presents the returned RAM word to the core. `ST_WRITE` drives the write strobe. The transitions are:
- IDLE→READ on an accepted start with a read request.
- IDLE→WRITE on an accepted start with only a write request.
- READ→CAPT always.
- CAPT→WRITE when a write is pending, otherwise CAPT→IDLE.
- WRITE→IDLE always.

Top module: `bdm_addr_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `ram_rd_en`, `ram_wr_en` and `rdata_valid` are all 0.
- R2: For a file offset other than 7'h00, the address is {status[6:5], file_sel[6:0]}.
- R3: For file offset 7'h00, the address is {status[7], fsr_reg[7:0]}.
- R4: An indirect access whose effective address has low seven bits 7'h00 delivers `rdata_out` = 8'h00 with `rdata_valid`, and `ram_rd_en` stays low.
- R5: An indirect self-referencing write never raises `ram_wr_en`, and the RAM content is left unchanged.
- R6: Each accepted write raises `ram_wr_en` for exactly one clock. It is raised in the cycle after the start for a write-only operation.
- R7: `ram_rd_en` is high for exactly one clock per read operation and never for a write-only operation. `rdata_valid` is high the following cycle, with the RAM word on `rdata_out`.
- R8: In a read-modify-write, the write strobe comes after the cycle in which `rdata_valid` is high, and it uses the same address as the read.
- R9: A `start` that arrives while `busy` is high is ignored. It causes no extra strobe and no access to its address.
- R10: The address is latched when an operation is accepted. Later changes to `status_reg`, `fsr_reg` or `file_sel` do not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| do_rd | input | 1 | Operation reads the file register |
| do_wr | input | 1 | Operation writes the file register |
| file_sel | input | 7 | File offset from the instruction |
| status_reg | input | 8 | Status: bit 7 indirect bank, bits 6:5 bank select |
| fsr_reg | input | 8 | File select pointer |
| wdata_in | input | 8 | Write data, taken during the write cycle |
| ram_rdata | input | 8 | Registered RAM read data |
| busy | output | 1 | Operation in progress |
| ram_rd_addr | output | 9 | RAM read address |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_wr_addr | output | 9 | RAM write address |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| rdata_out | output | 8 | Read result to the core |
| rdata_valid | output | 1 | `rdata_out` holds the read result |

## Verification
The bench aims at self-reference in an upper bank, pointer value 8'h80. A design that compared all eight FSR bits would read RAM there and leak stored data instead of returning zero. Self-referencing writes are checked against a pre-filled RAM word, which would be overwritten if the strobe were not gated. Read-modify-write ordering and a second start while busy are probed; a design that re-latched on that start would write to the wrong location. Direct and indirect accesses run in several banks, so a swapped or misplaced bank bit produces a wrong address.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_CAPT  = 2'd2,
        ST_WRITE = 2'd3
    } bdm_state_t;
endpackage

// File: rtl/bdm_addr_calc.sv
module bdm_addr_calc #(
    parameter int FILE_W   = 7,
    parameter int BANK_W   = 2,
    parameter int STAT_W   = 8,
    parameter int IND_OFF  = 0,
    parameter int IRP_BIT  = 7,
    parameter int RP_LO    = 5,
    localparam int ADDR_W  = FILE_W + BANK_W,
    localparam int PTR_W   = ADDR_W - 1
) (
    input  logic [FILE_W-1:0] file_sel,
    input  logic [STAT_W-1:0] status_reg,
    input  logic [PTR_W-1:0]  fsr_reg,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              self_ref
);
    logic is_ind;

    always_comb begin
        is_ind = (file_sel == FILE_W'(IND_OFF));
        if (is_ind)
            eff_addr = {status_reg[IRP_BIT], fsr_reg};
        else
            eff_addr = {status_reg[RP_LO+BANK_W-1:RP_LO], file_sel};
        self_ref = is_ind && (eff_addr[FILE_W-1:0] == FILE_W'(IND_OFF));
    end
endmodule

// File: rtl/bdm_ctrl.sv
module bdm_ctrl
    import bdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic do_rd,
    input  logic do_wr,
    output logic accept,
    output logic busy,
    output logic in_read,
    output logic in_capt,
    output logic in_write
);
    bdm_state_t state, nxt;
    logic       wr_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wr_pend <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) wr_pend <= do_wr;
        end
    end

    always_comb begin
        accept = (state == ST_IDLE) && start && (do_rd || do_wr);
        nxt    = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = do_rd ? ST_READ : ST_WRITE;
            ST_READ:  nxt = ST_CAPT;
            ST_CAPT:  nxt = wr_pend ? ST_WRITE : ST_IDLE;
            ST_WRITE: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        in_read  = (state == ST_READ);
        in_capt  = (state == ST_CAPT);
        in_write = (state == ST_WRITE);
    end

    // R6: the write state lasts one cycle
    p_write_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_write |=> !in_write);
    // R7: a read state is always followed by the capture state
    p_read_then_capt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_read |=> in_capt);
    // R9: start while busy does not restart a read
    p_busy_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !in_capt) |=> !in_read);
endmodule

// File: rtl/bdm_addr_unit.sv
module bdm_addr_unit #(
    parameter int FILE_W  = 7,
    parameter int BANK_W  = 2,
    parameter int DATA_W  = 8,
    parameter int IND_OFF = 0,
    parameter int IRP_BIT = 7,
    parameter int RP_LO   = 5,
    localparam int ADDR_W = FILE_W + BANK_W,
    localparam int PTR_W  = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              do_rd,
    input  logic              do_wr,
    input  logic [FILE_W-1:0] file_sel,
    input  logic [DATA_W-1:0] status_reg,
    input  logic [PTR_W-1:0]  fsr_reg,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              busy,
    output logic [ADDR_W-1:0] ram_rd_addr,
    output logic              ram_rd_en,
    output logic [ADDR_W-1:0] ram_wr_addr,
    output logic              ram_wr_en,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] rdata_out,
    output logic              rdata_valid
);
    logic [ADDR_W-1:0] eff_addr, addr_q;
    logic              self_ref, self_q;
    logic              accept, in_read, in_capt, in_write;

    bdm_addr_calc #(
        .FILE_W(FILE_W), .BANK_W(BANK_W), .STAT_W(DATA_W),
        .IND_OFF(IND_OFF), .IRP_BIT(IRP_BIT), .RP_LO(RP_LO)
    ) u_calc (
        .file_sel(file_sel), .status_reg(status_reg), .fsr_reg(fsr_reg),
        .eff_addr(eff_addr), .self_ref(self_ref)
    );

    bdm_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .do_rd(do_rd), .do_wr(do_wr),
        .accept(accept), .busy(busy), .in_read(in_read),
        .in_capt(in_capt), .in_write(in_write)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            self_q <= 1'b0;
        end else if (accept) begin
            addr_q <= eff_addr;
            self_q <= self_ref;
        end
    end

    always_comb begin
        ram_rd_addr = addr_q;
        ram_wr_addr = addr_q;
        ram_rd_en   = in_read && !self_q;
        ram_wr_en   = in_write && !self_q;
        ram_wdata   = wdata_in;
        rdata_valid = in_capt;
        rdata_out   = (in_capt && !self_q) ? ram_rdata : '0;
    end

    // R4: a self-referencing access never strobes a RAM read
    p_no_self_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (self_q && busy) |-> !ram_rd_en);
    // R5: a self-referencing access never strobes a RAM write
    p_no_self_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (self_q && busy) |-> !ram_wr_en);
    // R10: the latched address holds while an operation runs
    p_addr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ram_rd_addr));
    // R7: a read strobe is followed by valid data
    p_rd_then_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |=> rdata_valid);
endmodule

// File: tb/sim_bdm_addr_unit.sv
module sim_bdm_addr_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, do_rd = 1'b0, do_wr = 1'b0;
    logic [6:0] file_sel = '0;
    logic [7:0] status_reg = '0, fsr_reg = '0, wdata_in = '0;
    logic [7:0] ram_q;
    logic       busy, ram_rd_en, ram_wr_en, rdata_valid;
    logic [8:0] ram_rd_addr, ram_wr_addr;
    logic [7:0] ram_wdata, rdata_out;

    logic [7:0] mem [512];
    int total = 0, bad = 0;
    bit finished = 0;

    // results of the last operation
    int         n_rd, n_wr, n_val, cyc_val, cyc_wr, first_wr;
    logic [8:0] r_addr, w_addr;
    logic [7:0] r_data;

    always #2 clk = ~clk;

    bdm_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .do_rd(do_rd), .do_wr(do_wr),
        .file_sel(file_sel), .status_reg(status_reg), .fsr_reg(fsr_reg),
        .wdata_in(wdata_in), .ram_rdata(ram_q), .busy(busy),
        .ram_rd_addr(ram_rd_addr), .ram_rd_en(ram_rd_en),
        .ram_wr_addr(ram_wr_addr), .ram_wr_en(ram_wr_en),
        .ram_wdata(ram_wdata), .rdata_out(rdata_out), .rdata_valid(rdata_valid)
    );

    always_ff @(posedge clk) begin
        if (ram_wr_en) mem[ram_wr_addr] <= ram_wdata;
        if (ram_rd_en) ram_q <= mem[ram_rd_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one operation, observed each negedge until idle
    task automatic run_op(input bit rd, input bit wr, input logic [6:0] f,
                          input logic [7:0] st, input logic [7:0] fs, input logic [7:0] wd);
        @(negedge clk);
        start = 1; do_rd = rd; do_wr = wr; file_sel = f;
        status_reg = st; fsr_reg = fs; wdata_in = wd;
        n_rd = 0; n_wr = 0; n_val = 0; cyc_val = -1; cyc_wr = -1; first_wr = -1;
        r_addr = '0; w_addr = '0; r_data = '0;
        for (int c = 1; c < 10; c++) begin
            @(negedge clk);
            start = 0;
            if (ram_rd_en) begin n_rd++; r_addr = ram_rd_addr; end
            if (ram_wr_en) begin n_wr++; w_addr = ram_wr_addr; cyc_wr = c; end
            if (rdata_valid) begin n_val++; r_data = rdata_out; cyc_val = c; end
            if (!busy) break;
        end
    endtask

    task automatic t_reset;
        chk(!busy && !ram_rd_en, "R1", {busy, ram_rd_en}, 0);
        chk(!ram_wr_en && !rdata_valid, "R1", {ram_wr_en, rdata_valid}, 0);
    endtask

    task automatic t_direct;
        // bank 2, offset 0x35 -> 0x135
        run_op(0, 1, 7'h35, 8'h40, 8'h00, 8'hA7);
        chk(w_addr == 9'h135, "R2", w_addr, 9'h135);
        chk(n_wr == 1 && cyc_wr == 1, "R6", n_wr, 1);
        chk(n_rd == 0, "R7", n_rd, 0);
        chk(mem[9'h135] == 8'hA7, "R2", mem[9'h135], 8'hA7);
        // bank 3 read of FSR offset is a plain direct access
        mem[9'h184] = 8'h3C;
        run_op(1, 0, 7'h04, 8'h60, 8'h12, 8'h00);
        chk(r_addr == 9'h184, "R2", r_addr, 9'h184);
        chk(n_rd == 1 && n_val == 1, "R7", n_rd, 1);
        chk(r_data == 8'h3C, "R7", r_data, 8'h3C);
        chk(n_wr == 0, "R7", n_wr, 0);
    endtask

    task automatic t_indirect;
        // irp=1, fsr=0x9B -> 0x19B, bank bits must be ignored
        run_op(0, 1, 7'h00, 8'hE0, 8'h9B, 8'h55);
        chk(w_addr == 9'h19B, "R3", w_addr, 9'h19B);
        chk(mem[9'h19B] == 8'h55, "R3", mem[9'h19B], 8'h55);
        run_op(1, 0, 7'h00, 8'h00, 8'h21, 8'h00);
        mem[9'h021] = mem[9'h021];
        chk(r_addr == 9'h021, "R3", r_addr, 9'h021);
    endtask

    task automatic t_selfref;
        mem[9'h080] = 8'hC3;
        mem[9'h100] = 8'h5A;
        // fsr=0x80, irp=0 -> self reference in upper half
        run_op(1, 0, 7'h00, 8'h00, 8'h80, 8'h00);
        chk(n_val == 1 && r_data == 8'h00, "R4", r_data, 0);
        chk(n_rd == 0, "R4", n_rd, 0);
        // irp=1, fsr=0x00 -> 0x100, write must be dropped
        run_op(0, 1, 7'h00, 8'h80, 8'h00, 8'hFF);
        chk(n_wr == 0, "R5", n_wr, 0);
        chk(mem[9'h100] == 8'h5A, "R5", mem[9'h100], 8'h5A);
        // self RMW: read zero, no write
        run_op(1, 1, 7'h00, 8'h80, 8'h80, 8'h11);
        chk(r_data == 8'h00 && n_wr == 0, "R5", {r_data, 8'(n_wr)}, 0);
    endtask

    task automatic t_rmw;
        mem[9'h0A2] = 8'h19;
        run_op(1, 1, 7'h22, 8'h20, 8'h00, 8'h77);
        chk(r_data == 8'h19, "R8", r_data, 8'h19);
        chk(cyc_wr > cyc_val && cyc_val > 0, "R8", cyc_wr, cyc_val + 1);
        chk(w_addr == r_addr && w_addr == 9'h0A2, "R8", w_addr, 9'h0A2);
        chk(n_wr == 1, "R6", n_wr, 1);
        chk(mem[9'h0A2] == 8'h77, "R8", mem[9'h0A2], 8'h77);
    endtask

    task automatic t_busy_latch;
        int nw = 0, nr = 0;
        logic [8:0] ra = '0;
        mem[9'h011] = 8'h44;
        mem[9'h07E] = 8'h00;
        @(negedge clk);
        start = 1; do_rd = 1; do_wr = 0; file_sel = 7'h11; status_reg = 8'h00;
        @(negedge clk);
        // second start while busy, and inputs changed (R9, R10)
        start = 1; do_rd = 0; do_wr = 1; file_sel = 7'h7E;
        status_reg = 8'hE0; fsr_reg = 8'h33; wdata_in = 8'hEE;
        if (ram_rd_en) begin nr++; ra = ram_rd_addr; end
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            start = 0;
            if (ram_rd_en) begin nr++; ra = ram_rd_addr; end
            if (ram_wr_en) nw++;
        end
        chk(ra == 9'h011 && nr == 1, "R10", ra, 9'h011);
        chk(nw == 0, "R9", nw, 0);
        chk(mem[9'h07E] == 8'h00, "R9", mem[9'h07E], 0);
        chk(!busy, "R9", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_indirect();
        t_selfref();
        t_rmw();
        t_busy_latch();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule